// File: doc/BRIEF.md
# Byte-Serial CRC-32 Table Engine

This block folds a message into a 32-bit cyclic redundancy check one byte per clock. Each accepted byte is XORed with the top byte of the running checksum. The result indexes a 256-word constant table, which is computed from the generator polynomial when the design is elaborated. The table word is then XORed with the other 24 checksum bits moved up by one byte. Bits are taken most significant first. The block applies no bit reflection and no final inversion.

A message is streamed with `in_valid` high on every byte. The first byte also carries `in_first`, which makes that step start from the seed value and not from the running checksum. The final byte carries `in_last`. One cycle after that byte, `crc_done` pulses and `crc_out` holds the finished checksum. Between messages, and on idle cycles, the register keeps its value.

Top module: `crc32_byte_engine`

## Requirements
- R1: While reset is held, and after it is released with no byte accepted, `crc_out` is 0xFFFFFFFF and `crc_done` is 0.
- R2: A byte accepted with `in_first` high is combined with the seed 0xFFFFFFFF, not with the running value. For example, byte 0xFF with `in_first` gives 0xFFFFFF00.
- R3: A byte accepted with `in_first` low continues from the current `crc_out`. A message sent without `in_first` after another message therefore yields the checksum of the two messages joined.
- R4: Per accepted byte, the new value is T[b XOR crc[31:24]] XOR (crc[23:0] << 8). T[i] is i·x^32 mod the generator 0x04C11DB7, with bit 31 as the highest power. The nine ASCII bytes "123456789", starting from the seed, give 0x0376E6E7.
- R5: `crc_out` takes the updated value at the clock edge that accepts the byte, so it shows each partial result one cycle after the byte.
- R6: On a cycle with `in_valid` low, `crc_out` does not change and `crc_done` is 0, whatever `in_byte`, `in_first` and `in_last` hold.
- R7: `crc_done` is 1 for exactly the one cycle after a byte accepted with `in_last`, and 0 at all other times.
- R8: For messages whose length is a multiple of eight bytes, the result equals that of a 64-bit-per-step division of the same bit stream from the same seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte on `in_byte` is consumed this cycle |
| in_byte | input | 8 | Message byte |
| in_first | input | 1 | Byte starts a message; seed replaces running value |
| in_last | input | 1 | Byte ends a message; `crc_done` follows |
| crc_out | output | 32 | Running / final checksum register |
| crc_done | output | 1 | One-cycle pulse after the final byte |

## Verification
The hardest case to reach is a restart. This is a byte flagged `in_first` that arrives while the register holds a partial value from an unfinished message, so the seed must win over live state. The bench streams part of a message without `in_last` and then immediately begins a new flagged message. It checks that the result matches the new message alone. The opposite case is covered by chaining a second message with the flag low, which must match the joined stream.

// File: rtl/crc_byte_pkg.sv
package crc_byte_pkg;
  localparam int CRC_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int TBL_DEPTH = 1 << BYTE_W;
  localparam int REST_W    = CRC_W - BYTE_W;

  // Remainder of idx * x^CRC_W divided by the generator (MSB-first).
  function automatic logic [CRC_W-1:0] tbl_word(input logic [BYTE_W-1:0] idx,
                                                 input logic [CRC_W-1:0]  poly);
    logic [CRC_W-1:0] r;
    r = {idx, {REST_W{1'b0}}};
    for (int k = 0; k < BYTE_W; k++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/crc_seed_sel.sv
module crc_seed_sel
  import crc_byte_pkg::*;
#(
  parameter logic [CRC_W-1:0] SEED = 32'hFFFF_FFFF
) (
  input  logic             start,
  input  logic [CRC_W-1:0] running,
  output logic [CRC_W-1:0] base
);
  always_comb begin
    if (start) base = SEED;
    else       base = running;
  end
endmodule

// File: rtl/crc_lut.sv
module crc_lut
  import crc_byte_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [BYTE_W-1:0] idx,
  output logic [CRC_W-1:0]  word
);
  logic [CRC_W-1:0] table_w [TBL_DEPTH];

  for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_entry
    assign table_w[i] = tbl_word(BYTE_W'(i), POLY);
  end

  assign word = table_w[idx];
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
  import crc_byte_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED = 32'hFFFF_FFFF,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_first,
  input  logic              in_last,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done
);
  logic              rst_sync_n;
  logic [CRC_W-1:0]  crc_q, crc_d, base, tbl_out, step;
  logic [BYTE_W-1:0] idx;
  logic              done_q, done_d, crc_en;

  crc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  crc_seed_sel #(.SEED(SEED)) u_seed (
    .start(in_first), .running(crc_q), .base(base)
  );

  assign idx = in_byte ^ base[CRC_W-1 -: BYTE_W];

  crc_lut #(.POLY(POLY)) u_lut (
    .idx(idx), .word(tbl_out)
  );

  // next-state logic
  always_comb begin
    step   = tbl_out ^ {base[REST_W-1:0], {BYTE_W{1'b0}}};
    crc_en = in_valid;
    crc_d  = crc_en ? step : crc_q;
    done_d = in_valid & in_last;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      crc_q  <= SEED;
      done_q <= 1'b0;
    end else begin
      if (crc_en) crc_q <= crc_d;
      done_q <= done_d;
    end
  end

  assign crc_out  = crc_q;
  assign crc_done = done_q;
endmodule

// File: rtl/crc32_byte_engine_chk.sv
module crc32_byte_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_byte,
  input logic        in_first,
  input logic        in_last,
  input logic [31:0] crc_out,
  input logic        crc_done
);
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(crc_out));

  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> crc_done);

  a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !crc_done);

  a_r2_seed_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && in_byte == 8'hFF) |=> crc_out == 32'hFFFF_FF00);

  a_r3_zero_index_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && crc_out[31:24] == in_byte)
      |=> crc_out == {$past(crc_out[23:0]), 8'h00});
endmodule

bind crc32_byte_engine crc32_byte_engine_chk u_chk (.*);

// File: tb/crc32_byte_engine_test.sv
module crc32_byte_engine_test;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [31:0] SEED = 32'hFFFF_FFFF;
  localparam int NVEC = 6;
  localparam logic [63:0] VEC_DATA [NVEC] = '{
    64'h0000_0000_0000_0000, 64'hFF00_0000_0000_0000, 64'hA5C3_0000_0000_0000,
    64'h0102_0304_0506_0708, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_0000};
  localparam int VEC_LEN [NVEC] = '{1, 1, 2, 8, 8, 4};

  logic clk = 1'b0;
  logic rst_n, in_valid, in_first, in_last, crc_done;
  logic [7:0]  in_byte;
  logic [31:0] crc_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  crc32_byte_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_first(in_first), .in_last(in_last), .crc_out(crc_out), .crc_done(crc_done)
  );

  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = c[31] ^ b[k];
      c  = c << 1;
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] c, input logic [63:0] w);
    logic [95:0] r;
    r = {w[63:32] ^ c, w[31:0], 32'h0};
    for (int k = 95; k >= 32; k--) begin
      if (r[k]) r[k-:33] = r[k-:33] ^ {1'b1, POLY};
    end
    return r[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic f, input logic l);
    in_valid = 1'b1; in_byte = b; in_first = f; in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp_c;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_first = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 crc in reset", crc_out, SEED);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 crc after reset", crc_out, SEED);
    check("R1 done after reset", {31'd0, crc_done}, 32'd0);

    // vector table walk (R4, R7, R8)
    for (int v = 0; v < NVEC; v++) begin
      exp_c = SEED;
      for (int i = 0; i < VEC_LEN[v]; i++) begin
        logic [7:0] b;
        b = VEC_DATA[v][63-8*i -: 8];
        exp_c = ref_byte(exp_c, b);
        put(b, i == 0, i == VEC_LEN[v] - 1);
      end
      check("R4 vector result", crc_out, exp_c);
      check("R7 done pulse", {31'd0, crc_done}, 32'd1);
      if (VEC_LEN[v] == 8) check("R8 word reference", crc_out, ref_word(SEED, VEC_DATA[v]));
      @(negedge clk);
      check("R7 done single cycle", {31'd0, crc_done}, 32'd0);
    end

    // R2: seed on first byte 0xFF
    put(8'hFF, 1'b1, 1'b1);
    check("R2 first byte FF", crc_out, 32'hFFFF_FF00);

    // R4 check value and R5 partial results
    begin
      string s;
      s = "123456789";
      exp_c = SEED;
      for (int i = 0; i < 9; i++) begin
        exp_c = ref_byte(exp_c, s[i]);
        put(s[i], i == 0, i == 8);
        if (i == 0 || i == 4) check("R5 partial value", crc_out, exp_c);
      end
      check("R4 check value", crc_out, 32'h0376_E6E7);
    end

    // R6: idle cycles with noisy controls
    exp_c = crc_out;
    for (int i = 0; i < 5; i++) begin
      in_byte = 8'(i * 37); in_first = 1'b1; in_last = 1'b1;
      @(negedge clk);
      check("R6 hold on idle", crc_out, exp_c);
      check("R6 no done on idle", {31'd0, crc_done}, 32'd0);
    end
    in_first = 1'b0; in_last = 1'b0;

    // R3: chaining a second message without first
    exp_c = SEED;
    for (int i = 0; i < 3; i++) begin
      exp_c = ref_byte(exp_c, 8'h10 + 8'(i));
      put(8'h10 + 8'(i), i == 0, i == 2);
    end
    for (int i = 0; i < 3; i++) begin
      exp_c = ref_byte(exp_c, 8'h70 + 8'(i));
      put(8'h70 + 8'(i), 1'b0, i == 2);
    end
    check("R3 chained message", crc_out, exp_c);

    // R2: restart mid-message, back to back
    in_valid = 1'b1; in_first = 1'b1; in_byte = 8'h5A;
    @(negedge clk);
    in_first = 1'b0; in_byte = 8'h3C;
    @(negedge clk);
    exp_c = ref_byte(ref_byte(SEED, 8'hC7), 8'h81);
    in_first = 1'b1; in_byte = 8'hC7;
    @(negedge clk);
    in_first = 1'b0; in_last = 1'b1; in_byte = 8'h81;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check("R2 restart seed", crc_out, exp_c);
    check("R7 done after restart", {31'd0, crc_done}, 32'd1);

    // R8: 16-byte message, two word steps
    begin
      logic [63:0] w0, w1;
      w0 = 64'h0123_4567_89AB_CDEF; w1 = 64'hFEDC_BA98_7654_3210;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] b;
        b = (i < 8) ? w0[63-8*i -: 8] : w1[63-8*(i-8) -: 8];
        put(b, i == 0, i == 15);
      end
      check("R8 sixteen bytes", crc_out, ref_word(ref_word(SEED, w0), w1));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule